// File: doc/BRIEF.md
# Demand-Slotted Multicast Byte Bus Arbiter

This block shares one byte-wide bus among a set of requesting master channels and a set of slave transmitters. In every clock cycle it gives the single bus slot to one master that has a byte waiting. Masters with nothing to send take no slot, so the whole bus capacity goes to the channels that have traffic. The winner is picked in rotating order: the master served last drops to the lowest priority in the next cycle. This gives every channel a fixed worst-case wait, whatever the load on the others.

Each master offers a byte together with a destination mask that selects one or more slaves. A request is eligible only when every slave named in its mask is ready. A multicast byte therefore goes to all of its targets in the same transfer or waits as a whole. The accept pulse back to the master is combinational. Its valid and ready signals form an ordinary handshake. The winning byte, its mask, the index of its master and a busy flag are registered, and the slaves see them in the cycle that follows the grant.

Top module: `mbus_mcast_arb`

## Requirements
- R1: While `rst` is high, no `m_ready` bit is asserted. After reset all registered outputs read zero. With the pointer at its reset value, the first grant goes to master 0.
- R2: Master i is granted only when `m_valid[i]` is 1 and every slave whose bit is set in its mask slice `m_dest[i*N_SLAVES +: N_SLAVES]` has its `s_ready` bit at 1 in the same cycle.
- R3: At most one bit of `m_ready` is 1 in any cycle.
- R4: Demand slotting: whenever at least one master is eligible, some master is granted in that cycle. An idle master never takes a slot.
- R5: Rotating priority: the grant goes to the first eligible master found by searching upward from the index after the previous winner and wrapping from N_MASTERS-1 to 0.
- R6: A master that stays eligible waits at most N_MASTERS-1 consecutive cycles without a grant.
- R7: In the cycle after a grant, `s_valid` equals the winner's mask, `s_data` its byte, `s_owner` its index and `s_busy` is 1. After a cycle with no grant, all four outputs are zero.
- R8: Whole multicast: a nonzero `s_valid` never includes a slave that was not ready in the grant cycle.
- R9: A request whose destination mask is all zero is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| m_valid | input | N_MASTERS | Master i has a byte waiting |
| m_data | input | 8*N_MASTERS | Byte of master i at bits [8i+7:8i] |
| m_dest | input | N_SLAVES*N_MASTERS | Destination mask of master i at slice i, bit j selects slave j |
| m_ready | output | N_MASTERS | Accept pulse, one-hot or zero, same cycle as the request |
| s_ready | input | N_SLAVES | Slave j can take a byte in the next cycle |
| s_valid | output | N_SLAVES | Registered per-slave strobe: slave j latches `s_data` |
| s_data | output | 8 | Registered bus byte |
| s_owner | output | clog2(N_MASTERS) | Index of the master that owns the current slot |
| s_busy | output | 1 | The current slot carries a transfer |

## Verification
The bench builds the block at its default size of twelve masters and twelve slaves, the full width the arbiter is sized for. At that size the rotation wraps through a pointer that is not a power of two. The multicast masks are wide enough that partial slave readiness is common. Fully loaded runs drive the wait of a master to its limit of eleven cycles. Further runs mix fully idle traffic, a lone requester that wins every cycle, and requests with empty masks next to valid ones. These show that demand slotting and the eligibility gate work for any placement of the previous winner.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_LANES = 32;

    typedef logic [BYTE_W-1:0]    byte_t;
    typedef logic [MAX_LANES-1:0] lane_mask_t;

    // Payload that crosses the slot register
    typedef struct packed {
        logic  busy;
        byte_t data;
    } beat_t;

    // A request may go only if it names at least one lane and all named lanes are ready
    function automatic logic lanes_cover(lane_mask_t want, lane_mask_t ready);
        return (want != '0) && ((want & ~ready) == '0);
    endfunction

    // Circular index step below an upper bound n
    function automatic int rr_next(int base, int step, int n);
        int j;
        j = base + step;
        if (j >= n) j = j - n;
        return j;
    endfunction

endpackage

// File: rtl/mbus_elig.sv
module mbus_elig #(
    parameter int N = 12,
    parameter int M = 12
) (
    input  logic [N-1:0]   m_valid,
    input  logic [N*M-1:0] m_dest,
    input  logic [M-1:0]   s_ready,
    input  logic           enable,
    output logic [N-1:0]   elig
);
    import mbus_pkg::*;

    lane_mask_t ready_ext;
    assign ready_ext = lane_mask_t'(s_ready);

    for (genvar i = 0; i < N; i++) begin : g_req
        lane_mask_t want;
        assign want    = lane_mask_t'(m_dest[i*M +: M]);
        assign elig[i] = enable && m_valid[i] && lanes_cover(want, ready_ext);
    end

endmodule

// File: rtl/mbus_rr_pick.sv
module mbus_rr_pick #(
    parameter int N     = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] win
);
    import mbus_pkg::*;

    localparam int CW = $clog2(N + 1);

    logic [IDX_W-1:0] last_q;
    logic             found_c;

    // Search starts one past the previous winner, so that winner is tried last
    always_comb begin
        grant   = '0;
        win     = '0;
        found_c = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = rr_next(int'(last_q), k, N);
            if (!found_c && req[j]) begin
                found_c  = 1'b1;
                grant[j] = 1'b1;
                win      = IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last_q <= IDX_W'(N - 1);
        else if (|req) last_q <= win;
    end

    p_one_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    p_no_idle_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|grant));

    // Wait counters for each requester, kept for the fairness bound
    for (genvar i = 0; i < N; i++) begin : g_wait
        logic [CW-1:0] wait_q;
        always_ff @(posedge clk) begin
            if (rst)                    wait_q <= '0;
            else if (req[i] && !grant[i]) wait_q <= wait_q + CW'(1);
            else                        wait_q <= '0;
        end
        p_wait_bound_r6: assert property (@(posedge clk) disable iff (rst)
            wait_q < CW'(N));
    end

endmodule

// File: rtl/mbus_beat_reg.sv
module mbus_beat_reg #(
    parameter int N     = 12,
    parameter int M     = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     grant,
    input  logic [IDX_W-1:0] win,
    input  logic [N*8-1:0]   m_data,
    input  logic [N*M-1:0]   m_dest,
    output mbus_pkg::beat_t  beat_q,
    output logic [M-1:0]     lanes_q,
    output logic [IDX_W-1:0] owner_q
);
    import mbus_pkg::*;

    beat_t            beat_d;
    logic [M-1:0]     lanes_d;
    logic [IDX_W-1:0] owner_d;

    always_comb begin
        beat_d  = '0;
        lanes_d = '0;
        owner_d = '0;
        if (|grant) begin
            beat_d.busy = 1'b1;
            beat_d.data = m_data[int'(win)*BYTE_W +: BYTE_W];
            lanes_d     = m_dest[int'(win)*M +: M];
            owner_d     = win;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            lanes_q <= '0;
            owner_q <= '0;
        end else begin
            beat_q  <= beat_d;
            lanes_q <= lanes_d;
            owner_q <= owner_d;
        end
    end

endmodule

// File: rtl/mbus_mcast_arb.sv
module mbus_mcast_arb #(
    parameter  int N_MASTERS = 12,
    parameter  int N_SLAVES  = 12,
    localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_MASTERS-1:0]      m_valid,
    input  logic [N_MASTERS*8-1:0]    m_data,
    input  logic [N_SLAVES*N_MASTERS-1:0] m_dest,
    output logic [N_MASTERS-1:0]      m_ready,
    input  logic [N_SLAVES-1:0]       s_ready,
    output logic [N_SLAVES-1:0]       s_valid,
    output logic [7:0]                s_data,
    output logic [IDX_W-1:0]          s_owner,
    output logic                      s_busy
);
    import mbus_pkg::*;

    logic [N_MASTERS-1:0] elig;
    logic [N_MASTERS-1:0] grant;
    logic [IDX_W-1:0]     win;
    beat_t                beat_q;

    mbus_elig #(.N(N_MASTERS), .M(N_SLAVES)) u_elig (
        .m_valid (m_valid),
        .m_dest  (m_dest),
        .s_ready (s_ready),
        .enable  (!rst),
        .elig    (elig)
    );

    mbus_rr_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .req   (elig),
        .grant (grant),
        .win   (win)
    );

    mbus_beat_reg #(.N(N_MASTERS), .M(N_SLAVES), .IDX_W(IDX_W)) u_beat (
        .clk     (clk),
        .rst     (rst),
        .grant   (grant),
        .win     (win),
        .m_data  (m_data),
        .m_dest  (m_dest),
        .beat_q  (beat_q),
        .lanes_q (s_valid),
        .owner_q (s_owner)
    );

    assign m_ready = grant;
    assign s_data  = beat_q.data;
    assign s_busy  = beat_q.busy;

    p_whole_multicast_r8: assert property (@(posedge clk) disable iff (rst)
        (|m_ready) |=> ((s_valid & ~$past(s_ready)) == '0));

    p_slot_filled_r7: assert property (@(posedge clk) disable iff (rst)
        (|m_ready) |=> (s_busy && (s_valid != '0)));

    p_slot_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !(|m_ready) |=> (!s_busy && (s_valid == '0) && (s_data == '0)));

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_chk
        p_no_empty_mask_r9: assert property (@(posedge clk) disable iff (rst)
            m_ready[i] |-> (m_valid[i] && (m_dest[i*N_SLAVES +: N_SLAVES] != '0)));
    end

    always_comb begin
        if (rst) p_quiet_in_reset_r1: assert (m_ready == '0);
    end

endmodule

// File: tb/sim_mbus_mcast_arb.sv
module sim_mbus_mcast_arb;
    localparam int N = 12;
    localparam int M = 12;
    localparam int IDX_W = $clog2(N);

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;   // 125 MHz

    logic [N-1:0]   mv;
    logic [N*8-1:0] md;
    logic [N*M-1:0] mdst;
    logic [N-1:0]   m_ready;
    logic [M-1:0]   sr;
    logic [M-1:0]   s_valid;
    logic [7:0]     s_data;
    logic [IDX_W-1:0] s_owner;
    logic           s_busy;

    mbus_mcast_arb #(.N_MASTERS(N), .N_SLAVES(M)) u0 (
        .clk(clk), .rst(rst), .m_valid(mv), .m_data(md), .m_dest(mdst),
        .m_ready(m_ready), .s_ready(sr), .s_valid(s_valid), .s_data(s_data),
        .s_owner(s_owner), .s_busy(s_busy)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    int         last = N - 1;
    logic [M-1:0] e_valid = '0;
    logic [7:0]   e_data = '0;
    int           e_owner = 0;
    logic         e_busy = 1'b0;
    logic [M-1:0] prev_ready = '0;
    int           waitc[N];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [M-1:0] one_hot_lane();
        return M'(1) << ($urandom % M);
    endfunction

    function automatic logic [M-1:0] ready_mask(int pct);
        logic [M-1:0] r;
        for (int j = 0; j < M; j++) r[j] = (($urandom % 100) < pct);
        return r;
    endfunction

    task automatic drive(input int phase);
        for (int i = 0; i < N; i++) md[i*8 +: 8] = 8'($urandom);
        case (phase)
            0: begin mv = '0; mdst = '0; sr = ready_mask(50); end
            1: begin mv = '1; mdst = '1; sr = '1; end
            2: begin
                mv = '0; mv[5] = 1'b1; mdst = '0;
                mdst[5*M +: M] = one_hot_lane(); sr = '1;
            end
            3: begin
                for (int i = 0; i < N; i++) begin
                    mv[i] = $urandom % 2;
                    mdst[i*M +: M] = one_hot_lane();
                end
                sr = ready_mask(80);
            end
            4: begin
                for (int i = 0; i < N; i++) begin
                    mv[i] = (($urandom % 4) != 0);
                    mdst[i*M +: M] = M'($urandom);
                end
                sr = ready_mask(92);
            end
            5: begin
                mv = '1;
                for (int i = 0; i < N; i++)
                    mdst[i*M +: M] = (i % 2 == 0) ? '0 : one_hot_lane();
                sr = '1;
            end
            default: begin
                for (int i = 0; i < N; i++) begin
                    mv[i] = $urandom % 2;
                    mdst[i*M +: M] = M'($urandom) & M'($urandom);
                end
                sr = ready_mask(75);
            end
        endcase
    endtask

    task automatic step(input int phase, input bit first_of_load);
        logic [N-1:0] elig;
        logic [N-1:0] empt;
        logic [N-1:0] expg;
        int w;
        int maxw;
        // Registered outputs from the previous grant decision
        chk("R7 s_valid", 64'(s_valid), 64'(e_valid));
        chk("R7 s_data", 64'(s_data), 64'(e_data));
        chk("R7 s_owner", 64'(s_owner), 64'(e_owner));
        chk("R7 s_busy", 64'(s_busy), 64'(e_busy));
        chk("R8 partial delivery", 64'(s_valid & ~prev_ready), 64'(0));
        drive(phase);
        #1;
        for (int i = 0; i < N; i++) begin
            logic [M-1:0] d;
            d = mdst[i*M +: M];
            empt[i] = (d == '0);
            elig[i] = mv[i] && (d != '0) && ((d & ~sr) == '0);
        end
        expg = '0;
        w = -1;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (last + k) % N;
            if (w < 0 && elig[j]) begin w = j; expg[j] = 1'b1; end
        end
        chk("R5 rotating grant", 64'(m_ready), 64'(expg));
        chk("R3 single grant", 64'($countones(m_ready) <= 1), 64'(1));
        chk("R2 grant only eligible", 64'(m_ready & ~elig), 64'(0));
        chk("R4 no idle slot", 64'((elig == '0) || (m_ready != '0)), 64'(1));
        chk("R9 empty mask", 64'(m_ready & empt), 64'(0));
        if (first_of_load) chk("R1 first grant to master 0", 64'(m_ready), 64'(1));
        maxw = 0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && !m_ready[i]) waitc[i]++;
            else waitc[i] = 0;
            if (waitc[i] > maxw) maxw = waitc[i];
        end
        chk("R6 wait bound", 64'(maxw <= N - 1), 64'(1));
        if (w >= 0) begin
            last = w;
            e_valid = mdst[w*M +: M];
            e_data = md[w*8 +: 8];
            e_owner = w;
            e_busy = 1'b1;
        end else begin
            e_valid = '0; e_data = '0; e_owner = 0; e_busy = 1'b0;
        end
        prev_ready = sr;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung, expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) waitc[i] = 0;
        rst = 1'b1;
        mv = '0; md = '0; mdst = '0; sr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        drive(1);
        #1;
        chk("R1 no grant in reset", 64'(m_ready), 64'(0));
        @(negedge clk);
        mv = '0; mdst = '0; sr = '0;
        rst = 1'b0;
        chk("R1 reset s_valid", 64'(s_valid), 64'(0));
        chk("R1 reset s_busy", 64'(s_busy), 64'(0));
        chk("R1 reset s_owner", 64'(s_owner), 64'(0));
        chk("R1 reset s_data", 64'(s_data), 64'(0));
        repeat (40) step(0, 1'b0);
        step(1, 1'b1);
        repeat (59) step(1, 1'b0);
        repeat (40) step(2, 1'b0);
        repeat (300) step(3, 1'b0);
        repeat (300) step(4, 1'b0);
        repeat (60) step(5, 1'b0);
        repeat (1500) step(6, 1'b0);
        repeat (5) step(0, 1'b0);
        summary();
        $finish;
    end

endmodule